// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt conditions for a small 8-bit processor core and turns them into one request line plus a vector address. It takes a set of on-chip event pulses and two asynchronous external pins. Edge events are remembered in pending flags. Each source has its own enable bit, and one global gate sits over all of them. When an enabled source is pending and the gate is open, the block raises a request. The vector it presents belongs to the winning source under a fixed priority order.

The core accepts a request with a one-cycle accept pulse. That pulse shuts the gate and clears the flag of the source that won. A one-cycle return pulse opens the gate again. Software can also open the gate from inside a handler, which lets handlers nest. Each external pin has a 2-bit sense field that selects low level, falling edge or rising edge detection. A level-sensed pin has no flag and requests service only while it is held low.

The global gate is a two-state machine. In state GATE_SHUT the gate is closed: no request leaves the block and pending flags wait. In state GATE_OPEN requests pass through. The transition GATE_OPEN to GATE_SHUT happens when a request is accepted, or when software writes 0 to the gate bit. The transition GATE_SHUT to GATE_OPEN happens when a return pulse arrives, or when software writes 1 to the gate bit. The state machine comes out of reset in GATE_SHUT.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When `irq_ack` is high in a cycle where `irq_req` is high, the gate moves to GATE_SHUT, and `irq_req` is low from the next cycle on until the gate is opened again.
- R2: A write to address 5 loads `reg_wdata[0]` into the gate bit (1 = open), and reads of address 5 return it in bit 0. Writing 1 inside a handler lets a newly pending source raise `irq_req` (nesting).
- R3: When `irq_reti` is high and no accept is taken in the same cycle, the gate is open from the next cycle. An accept in the same cycle wins over a return, and a return wins over a software write to address 5.
- R4: An accept clears the pending flag of the winning source in the same clock edge. A new event for that source in the same cycle wins, and the flag stays set.
- R5: Writing 1 to a bit of a flag register clears that flag (address 1: bit 6 = external 0, bit 7 = external 1; address 3: bit j = event j). Writing 0 leaves the flag unchanged.
- R6: A pulse on `periph_evt[j]` sets flag j even while enable j or the gate is 0. The flag stays set until it is serviced or cleared by software.
- R7: `irq_vector` is 1 for external 0, 2 for external 1 and 3+j for event j. The lowest pending-and-enabled vector wins. `irq_vector` is 0 whenever `irq_req` is low.
- R8: Sense code 00 requests service while the synchronised pin is low and sets no flag. Code 01 never requests. The sense field lives at address 4: bits 1:0 for external 0, bits 3:2 for external 1.
- R9: Code 10 sets the pin's flag on a falling edge and code 11 on a rising edge. Detection runs through a two-flop synchroniser, so the flag is readable three clock edges after the pin changes.
- R10: Address 0 holds the external enables, with external 1 at bit 7 and external 0 at bit 6. Its other bits read 0 and ignore writes. Address 2 holds the event enables in bits 0 to NUM_PERIPH-1.
- R11: After reset, `irq_req` and `irq_vector` are 0 and every register (addresses 0 to 5) reads 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| periph_evt | input | NUM_PERIPH | One-cycle event pulses from peripherals |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Core accepts the current request |
| irq_reti | input | 1 | Core has executed a return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | VEC_W | Vector address of the winning source |

## Verification
Some faults show at the ports within the next cycle. A flag stuck high, a dropped clear or a gate left open after an accept each show as a wrong `irq_req` or `irq_vector` once the gate is open. A wrong priority order shows in the same cycle as a wrong vector. A synchroniser with the wrong number of stages moves the flag's appearance at the flag registers by one cycle, so the bench compares outputs and register reads against a behavioural model on every clock rather than only at the end of each scenario. Register faults, such as writable read-only bits or a write-0 that clears a flag, show on the very next read.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_OFF  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 8;

    localparam logic [REG_ADDR_W-1:0] A_EXT_EN   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] A_EXT_FLAG = 3'd1;
    localparam logic [REG_ADDR_W-1:0] A_EVT_EN   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] A_EVT_FLAG = 3'd3;
    localparam logic [REG_ADDR_W-1:0] A_SENSE    = 3'd4;
    localparam logic [REG_ADDR_W-1:0] A_GATE     = 3'd5;

    localparam int EXT_COUNT    = 2;
    localparam int EXT_BIT_BASE = 6;

endpackage

// File: rtl/irq_sense.sv
module irq_sense
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_async,
    input  logic [1:0] mode,
    output logic       level_req,
    output logic       edge_hit
);

    logic sync_a, sync_b, last_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            last_b <= 1'b0;
        end else begin
            sync_a <= pin_async;
            sync_b <= sync_a;
            last_b <= sync_b;
        end
    end

    always_comb begin
        level_req = 1'b0;
        edge_hit  = 1'b0;
        unique case (mode)
            SENSE_LOW:  level_req = !sync_b;
            SENSE_OFF:  ;
            SENSE_FALL: edge_hit = last_b && !sync_b;
            SENSE_RISE: edge_hit = !last_b && sync_b;
        endcase
    end

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (!edge_hit || !$stable(mode))) else $error("edge held"); // R9

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0] src_req,
    output logic [NUM_SRC-1:0] grant,
    output logic               any_req,
    output logic [VEC_W-1:0]   vector
);

    always_comb begin
        grant  = '0;
        vector = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src_req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vector   = VEC_W'(i + 1);
            end
        end
    end

    assign any_req = |src_req;

endmodule

// File: rtl/irq_gate_fsm.sv
module irq_gate_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic reti,
    input  logic sw_wr,
    input  logic sw_val,
    output logic gate_open
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_SHUT: begin
                if (reti || (sw_wr && sw_val))
                    state_d = GATE_OPEN;
            end
            GATE_OPEN: begin
                if (take)
                    state_d = GATE_SHUT;
                else if (!reti && sw_wr && !sw_val)
                    state_d = GATE_SHUT;
            end
        endcase
    end

    always_comb begin
        gate_open = (state_q == GATE_OPEN);
    end

    AST_TAKE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gate_open) else $error("gate open after take"); // R1
    AST_RETI_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !take) |=> gate_open) else $error("gate shut after reti"); // R3
    AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !reti && !take) |=> (gate_open == $past(sw_val))) else $error("gate write lost"); // R2

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 6,
    parameter int VEC_W      = $clog2(NUM_PERIPH + 3)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            ext_pin,
    input  logic [NUM_PERIPH-1:0] periph_evt,
    input  logic [2:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  irq_ack,
    input  logic                  irq_reti,
    output logic                  irq_req,
    output logic [VEC_W-1:0]      irq_vector
);

    localparam int NUM_SRC = NUM_PERIPH + EXT_COUNT;

    logic [EXT_COUNT-1:0]  ext_en_q, ext_flag_q, ext_lvl, ext_hit, ext_pend;
    logic [NUM_PERIPH-1:0] evt_en_q, evt_flag_q;
    logic [2*EXT_COUNT-1:0] sense_q;
    logic [NUM_SRC-1:0]    src_req, grant;
    logic                  any_req, gate_open, take;
    logic [VEC_W-1:0]      enc_vector;

    logic wr_ext_en, wr_ext_flag, wr_evt_en, wr_evt_flag, wr_sense, wr_gate;

    assign wr_ext_en   = reg_we && (reg_addr == A_EXT_EN);
    assign wr_ext_flag = reg_we && (reg_addr == A_EXT_FLAG);
    assign wr_evt_en   = reg_we && (reg_addr == A_EVT_EN);
    assign wr_evt_flag = reg_we && (reg_addr == A_EVT_FLAG);
    assign wr_sense    = reg_we && (reg_addr == A_SENSE);
    assign wr_gate     = reg_we && (reg_addr == A_GATE);

    // external pin front ends
    for (genvar g = 0; g < EXT_COUNT; g++) begin : g_ext
        irq_sense u_sense (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (ext_pin[g]),
            .mode      (sense_q[2*g +: 2]),
            .level_req (ext_lvl[g]),
            .edge_hit  (ext_hit[g])
        );

        assign ext_pend[g] = ext_lvl[g] || (sense_q[2*g+1] && ext_flag_q[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ext_flag_q[g] <= 1'b0;
                ext_en_q[g]   <= 1'b0;
            end else begin
                if (ext_hit[g])
                    ext_flag_q[g] <= 1'b1;
                else if ((take && grant[g]) || (wr_ext_flag && reg_wdata[EXT_BIT_BASE+g]))
                    ext_flag_q[g] <= 1'b0;
                if (wr_ext_en)
                    ext_en_q[g] <= reg_wdata[EXT_BIT_BASE+g];
            end
        end
    end

    // peripheral event flags
    for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_flag_q[j] <= 1'b0;
                evt_en_q[j]   <= 1'b0;
            end else begin
                if (periph_evt[j])
                    evt_flag_q[j] <= 1'b1;
                else if ((take && grant[EXT_COUNT+j]) || (wr_evt_flag && reg_wdata[j]))
                    evt_flag_q[j] <= 1'b0;
                if (wr_evt_en)
                    evt_en_q[j] <= reg_wdata[j];
            end
        end

        AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
            periph_evt[j] |=> evt_flag_q[j]) else $error("event lost"); // R6
        AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (take && grant[EXT_COUNT+j] && !periph_evt[j]) |=> !evt_flag_q[j]) else $error("flag kept"); // R4
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sense_q <= '0;
        else if (wr_sense) sense_q <= reg_wdata[2*EXT_COUNT-1:0];
    end

    assign src_req = {evt_flag_q & evt_en_q, ext_pend & ext_en_q};

    irq_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .VEC_W   (VEC_W)
    ) u_enc (
        .src_req (src_req),
        .grant   (grant),
        .any_req (any_req),
        .vector  (enc_vector)
    );

    assign irq_req    = gate_open && any_req;
    assign irq_vector = irq_req ? enc_vector : '0;
    assign take       = irq_ack && irq_req;

    irq_gate_fsm u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .reti      (irq_reti),
        .sw_wr     (wr_gate),
        .sw_val    (reg_wdata[0]),
        .gate_open (gate_open)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_EXT_EN:   reg_rdata[EXT_BIT_BASE +: EXT_COUNT] = ext_en_q;
            A_EXT_FLAG: reg_rdata[EXT_BIT_BASE +: EXT_COUNT] = ext_flag_q;
            A_EVT_EN:   reg_rdata = 8'(evt_en_q);
            A_EVT_FLAG: reg_rdata = 8'(evt_flag_q);
            A_SENSE:    reg_rdata = 8'(sense_q);
            A_GATE:     reg_rdata[0] = gate_open;
            default:    reg_rdata = '0;
        endcase
    end

    AST_REQ_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !irq_req) else $error("request after accept"); // R1
    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector != '0 && irq_vector <= VEC_W'(NUM_SRC))) else $error("bad vector"); // R7
    AST_EXT_EN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_EXT_EN) |-> (reg_rdata[EXT_BIT_BASE-1:0] == '0)) else $error("ro bits set"); // R10

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb_top;

    localparam int NP = 6;
    localparam int NS = NP + 2;
    localparam int VW = $clog2(NP + 3);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ext_pin = 2'b11;
    logic [NP-1:0] periph_evt = '0;
    logic [2:0]    reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          irq_ack = 1'b0;
    logic          irq_reti = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_vec_ctrl #(.NUM_PERIPH(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .periph_evt(periph_evt),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_reti(irq_reti), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // ---------------- behavioural model ----------------
    int m_gie;
    int m_een[2], m_ef[2], m_sense[2];
    int m_pen[NP], m_pf[NP];
    int s1[2], s2[2], s3[2];

    function automatic int m_best();
        int pend;
        for (int g = 0; g < 2; g++) begin
            if (m_sense[g] == 0) pend = (s2[g] == 0);
            else if (m_sense[g] == 1) pend = 0;
            else pend = m_ef[g];
            if (pend != 0 && m_een[g] != 0) return g + 1;
        end
        for (int j = 0; j < NP; j++)
            if (m_pf[j] != 0 && m_pen[j] != 0) return j + 3;
        return 0;
    endfunction

    function automatic int m_req();
        return (m_gie != 0 && m_best() != 0) ? 1 : 0;
    endfunction

    function automatic int m_vec();
        return (m_req() != 0) ? m_best() : 0;
    endfunction

    function automatic int m_read(int a);
        int v = 0;
        case (a)
            0: v = m_een[1] * 128 + m_een[0] * 64;
            1: v = m_ef[1] * 128 + m_ef[0] * 64;
            2: for (int j = 0; j < NP; j++) v += m_pen[j] << j;
            3: for (int j = 0; j < NP; j++) v += m_pf[j] << j;
            4: v = m_sense[1] * 4 + m_sense[0];
            5: v = m_gie;
            default: v = 0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gie = 0;
            for (int g = 0; g < 2; g++) begin
                m_een[g] = 0; m_ef[g] = 0; m_sense[g] = 0; s1[g] = 0; s2[g] = 0; s3[g] = 0;
            end
            for (int j = 0; j < NP; j++) begin m_pen[j] = 0; m_pf[j] = 0; end
        end else begin
            int take, win, hit;
            int n_ef[2];
            int n_pf[NP];
            take = (irq_ack && m_req() != 0) ? 1 : 0;
            win  = m_best();
            for (int g = 0; g < 2; g++) begin
                hit = 0;
                if (m_sense[g] == 2 && s3[g] == 1 && s2[g] == 0) hit = 1;
                if (m_sense[g] == 3 && s3[g] == 0 && s2[g] == 1) hit = 1;
                n_ef[g] = m_ef[g];
                if (hit != 0) n_ef[g] = 1;
                else if ((take != 0 && win == g + 1) || (reg_we && reg_addr == 1 && reg_wdata[6+g])) n_ef[g] = 0;
            end
            for (int j = 0; j < NP; j++) begin
                n_pf[j] = m_pf[j];
                if (periph_evt[j]) n_pf[j] = 1;
                else if ((take != 0 && win == j + 3) || (reg_we && reg_addr == 3 && reg_wdata[j])) n_pf[j] = 0;
            end
            if (take != 0) m_gie = 0;
            else if (irq_reti) m_gie = 1;
            else if (reg_we && reg_addr == 5) m_gie = int'(reg_wdata[0]);
            for (int g = 0; g < 2; g++) begin
                m_ef[g] = n_ef[g];
                if (reg_we && reg_addr == 0) m_een[g] = int'(reg_wdata[6+g]);
                s3[g] = s2[g]; s2[g] = s1[g]; s1[g] = int'(ext_pin[g]);
            end
            if (reg_we && reg_addr == 4) begin
                m_sense[0] = int'(reg_wdata[1:0]);
                m_sense[1] = int'(reg_wdata[3:2]);
            end
            for (int j = 0; j < NP; j++) begin
                m_pf[j] = n_pf[j];
                if (reg_we && reg_addr == 2) m_pen[j] = int'(reg_wdata[j]);
            end
        end
    end

    // per-cycle comparison, R7 ordering and R11 read-back through the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            checks++;
            if (int'(irq_req) != m_req() || int'(irq_vector) != m_vec() || int'(reg_rdata) != m_read(int'(reg_addr))) begin
                errors++;
                $display("FAIL R7 cycle compare: req %0d vec %0d rd %0h, expected req %0d vec %0d rd %0h",
                         irq_req, irq_vector, reg_rdata, m_req(), m_vec(), m_read(int'(reg_addr)));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk); reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk); reg_addr = 3'(a); #2; v = int'(reg_rdata);
    endtask

    task automatic pulse(int j);
        @(negedge clk); periph_evt[j] = 1'b1;
        @(negedge clk); periph_evt[j] = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic reti();
        @(negedge clk); irq_reti = 1'b1;
        @(negedge clk); irq_reti = 1'b0;
    endtask

    task automatic outs(string tag, int req, int vec);
        @(negedge clk); #2;
        chk(tag, int'(irq_req), req);
        chk(tag, int'(irq_vector), vec);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        outs("R11 reset outputs", 0, 0);
        for (int a = 0; a < 8; a++) begin rd(a, v); chk("R11 reset register", v, 0); end

        // R10 read-only bits of external enable register
        wr(0, 8'hFF); rd(0, v); chk("R10 ext enable bits", v, 8'hC0);
        wr(0, 8'h00);

        // R6 masked event latches
        pulse(2); rd(3, v); chk("R6 masked flag", v, 8'h04);
        outs("R6 no request while masked", 0, 0);
        wr(2, 8'h04); outs("R6 gate shut", 0, 0);
        wr(5, 1); outs("R2 gate opened by write", 1, 5);
        rd(5, v); chk("R2 gate reads 1", v, 1);

        // R1 / R4 accept
        ack(); outs("R1 request drops after accept", 0, 0);
        rd(5, v); chk("R1 gate shut", v, 0);
        rd(3, v); chk("R4 flag cleared on accept", v, 0);

        // R7 / R3 priority and return
        wr(2, 8'h3F); pulse(0); pulse(3);
        outs("R7 held while gate shut", 0, 0);
        reti(); outs("R3 return opens, R7 lowest wins", 1, 3);
        ack(); outs("R1 shut after second accept", 0, 0);
        reti(); outs("R7 next source", 1, 6);
        ack(); reti(); outs("R3 nothing left", 0, 0);

        // R5 write-one-to-clear
        wr(2, 0); pulse(1); pulse(4);
        rd(3, v); chk("R5 two flags", v, 8'h12);
        wr(3, 8'h02); rd(3, v); chk("R5 write one clears", v, 8'h10);
        wr(3, 8'h00); rd(3, v); chk("R5 write zero keeps", v, 8'h10);
        wr(3, 8'h10);

        // R2 nesting
        wr(2, 8'h21); pulse(5); outs("R2 outer request", 1, 8);
        ack(); outs("R2 inside handler", 0, 0);
        wr(5, 1); outs("R2 reopened, nothing pending", 0, 0);
        pulse(0); outs("R2 nested request", 1, 3);
        ack(); reti(); wr(2, 0);

        // R9 edge modes on external 0
        wr(4, 8'h03);
        @(negedge clk); ext_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, v); chk("R9 falling ignored in rise mode", v, 0);
        @(negedge clk); ext_pin[0] = 1'b1;
        @(negedge clk); @(negedge clk); #2; chk("R9 flag not yet after two edges", int'(dut_rd1()), 0);
        @(negedge clk); #2; chk("R9 flag after three edges", int'(dut_rd1()), 8'h40);
        wr(0, 8'h40); outs("R7 external 0 vector", 1, 1);
        ack(); rd(1, v); chk("R4 external flag cleared", v, 0);
        reti();
        wr(4, 8'h02);
        @(negedge clk); ext_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        wr(0, 0);
        rd(1, v); chk("R9 falling edge flag", v, 8'h40);
        wr(1, 8'h40); rd(1, v); chk("R5 external clear", v, 0);

        // R8 level mode on external 1
        wr(0, 8'h80);
        @(negedge clk); ext_pin[1] = 1'b0;
        repeat (3) @(negedge clk);
        outs("R8 level request", 1, 2);
        rd(1, v); chk("R8 no flag in level mode", v, 0);
        @(negedge clk); ext_pin[1] = 1'b1;
        repeat (3) @(negedge clk);
        outs("R8 level released", 0, 0);
        wr(4, 8'h06);
        @(negedge clk); ext_pin[1] = 1'b0;
        repeat (3) @(negedge clk);
        outs("R8 code 01 never requests", 0, 0);

        // R7 external priority
        wr(0, 0); wr(4, 8'h0E);
        @(negedge clk); ext_pin = 2'b11;
        repeat (4) @(negedge clk);
        @(negedge clk); ext_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, v); chk("R9 both external flags", v, 8'hC0);
        wr(0, 8'hC0); outs("R7 external 0 first", 1, 1);
        ack(); reti(); outs("R7 external 1 second", 1, 2);
        ack(); reti(); outs("R7 all serviced", 0, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

    function automatic logic [7:0] dut_rd1();
        return (reg_addr == 3'd1) ? reg_rdata : 8'hEE;
    endfunction

    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (irq_ack === 1'b0 && irq_reti === 1'b0 && reg_we === 1'b0) reg_addr = reg_addr;
        end
    end

endmodule